// File: doc/BRIEF.md
# Protection Unit Region Register Bank

This block is the software-visible configuration store of a small memory protection unit. A 32-bit bus slave port lets firmware program a control word and a set of protection regions. Each region has a base word and an attribute/size word, and a lookup block elsewhere on the chip consumes them. The region tables and the control bits leave the block as flat parallel buses, so the lookup logic sees every region at once.

Firmware reaches a region's words only through a region pointer. The pointer can be written directly, or it can be loaded as a side effect of a base write that carries its own region number. The base/attribute pair appears in a primary window and in three alias windows, which all behave the same way. An index that is out of range never corrupts state: that access has no effect. Each accepted change to the region tables raises a one-cycle strobe, so that the lookup side can discard any cached decisions.

Top module: `mpu_regbank`

## Requirements
- R1: After reset the control bits, the region pointer and every region's base and attribute words are zero, and the table-change strobe is low.
- R2: Every request (`bus_req` high at a rising edge) is answered with `bus_ready` high in the following cycle. For reads, `bus_rdata` carries the value in that same cycle. With no request, `bus_ready` is low.
- R3: Offset 0xD94 holds the control bits [2:0]: bit 0 enables protection, bit 1 keeps protection on in fault handlers, bit 2 enables the default background map. The bits drive the matching outputs and read back zero-extended.
- R4: Offset 0xD98 is the region pointer. A write with a value below `NUM_REGIONS` loads it. Any larger value is ignored and the pointer keeps its previous value.
- R5: A write to the base word (offset 0xD9C) with bit 4 clear stores bits [31:5] into the region selected by the pointer. Stored bits [4:0] are zero, and a read returns the pointed region's base.
- R6: A base write with bit 4 set takes the region from bits [3:0]. If that region is below `NUM_REGIONS`, the pointer is loaded with it and the base is stored there. Otherwise the whole write is dropped: the pointer, the tables and the strobe do not change.
- R7: A write to the attribute word (offset 0xDA0) stores all 32 bits into the pointed region. A read returns them.
- R8: The pairs at 0xDA4/0xDA8, 0xDAC/0xDB0 and 0xDB4/0xDB8 behave exactly like the base/attribute pair at 0xD9C/0xDA0.
- R9: Any other offset reads as zero, and a write to it changes no state and raises no strobe.
- R10: `tbl_changed` is high for exactly the one cycle after an accepted base or attribute write. It is low otherwise, including after writes that were ignored.
- R11: Region r's base and attribute words appear on `region_base[32*r +: 32]` and `region_attr[32*r +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion, one cycle after bus_req |
| prot_en | output | 1 | Control bit 0: protection enable |
| fault_prot_en | output | 1 | Control bit 1: protection kept on in fault handlers |
| bg_map_en | output | 1 | Control bit 2: default background map enable |
| region_base | output | 32*NUM_REGIONS | Flattened base words |
| region_attr | output | 32*NUM_REGIONS | Flattened attribute/size words |
| tbl_changed | output | 1 | One-cycle pulse after an accepted region write |

## Verification
The bench runs with six regions, so pointer values and embedded region numbers of 6 to 15 are in the 4-bit field but out of range. A design that clamps or wraps such an index would corrupt a live region or move the pointer. An embedded-region base write is directed at index `NUM_REGIONS` to catch a design that updates the pointer but drops the data, or the reverse. Every alias window is written and read, to expose a decoder that maps an alias to the wrong half of the pair. The strobe is compared after every access, including ignored writes. Without that, a design that pulses on every decoded write would go unnoticed and cause needless flushes downstream.

// File: rtl/mpu_regbank_pkg.sv
package mpu_regbank_pkg;

   localparam int DATA_W     = 32;
   localparam int IDX_W      = 4;    // width of the embedded region field
   localparam int MAX_REGION = 16;
   localparam int CTRL_W     = 3;
   localparam int BASE_LSB   = 5;    // base words hold bits [31:5]
   localparam int VALID_BIT  = 4;    // embedded-region flag in a base write

   localparam logic [11:0] OFF_CTRL = 12'hD94;
   localparam logic [11:0] OFF_RPTR = 12'hD98;
   localparam logic [11:0] OFF_PAIR = 12'hD9C;   // first base word
   localparam int          PAIR_STRIDE = 8;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_RPTR,
      SEL_BASE,
      SEL_ATTR
   } reg_sel_e;

endpackage

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
   import mpu_regbank_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_ALIAS = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam int NUM_WIN = NUM_ALIAS + 1;

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         initial $error("mpu_addr_decode: ADDR_W must be at least 12");
      end
      if (NUM_ALIAS < 0 || NUM_ALIAS > 3) begin : g_bad_alias
         initial $error("mpu_addr_decode: NUM_ALIAS must be 0..3");
      end
   endgenerate

   logic [ADDR_W-1:0] word_addr;
   assign word_addr = {addr[ADDR_W-1:2], 2'b00};

   logic [NUM_WIN-1:0] hit_base;
   logic [NUM_WIN-1:0] hit_attr;

   genvar w;
   generate
      for (w = 0; w < NUM_WIN; w++) begin : g_win
         localparam logic [ADDR_W-1:0] WB = ADDR_W'(OFF_PAIR) + ADDR_W'(w * PAIR_STRIDE);
         assign hit_base[w] = (word_addr == WB);
         assign hit_attr[w] = (word_addr == WB + ADDR_W'(4));
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (word_addr == ADDR_W'(OFF_CTRL))      sel = SEL_CTRL;
      else if (word_addr == ADDR_W'(OFF_RPTR)) sel = SEL_RPTR;
      else if (|hit_base)                      sel = SEL_BASE;
      else if (|hit_attr)                      sel = SEL_ATTR;
   end

endmodule

// File: rtl/mpu_region_table.sv
module mpu_region_table
   import mpu_regbank_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_base,
   input  logic                          wr_attr,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [DATA_W-1:0]             rd_base,
   output logic [DATA_W-1:0]             rd_attr,
   output logic [NUM_REGIONS*DATA_W-1:0] base_flat,
   output logic [NUM_REGIONS*DATA_W-1:0] attr_flat
);

   logic [NUM_REGIONS-1:0][DATA_W-1:0] base_q;
   logic [NUM_REGIONS-1:0][DATA_W-1:0] attr_q;

   genvar r;
   generate
      for (r = 0; r < NUM_REGIONS; r++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               base_q[r] <= '0;
               attr_q[r] <= '0;
            end else begin
               if (wr_base && wr_idx == IDX_W'(r))
                  base_q[r] <= {wdata[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
               if (wr_attr && wr_idx == IDX_W'(r))
                  attr_q[r] <= wdata;
            end
         end
         assign base_flat[r*DATA_W +: DATA_W] = base_q[r];
         assign attr_flat[r*DATA_W +: DATA_W] = attr_q[r];
      end
   endgenerate

   logic rd_in_range;
   assign rd_in_range = ({1'b0, rd_idx} < (IDX_W+1)'(NUM_REGIONS));

   always_comb begin
      rd_base = '0;
      rd_attr = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (rd_in_range && rd_idx == IDX_W'(i)) begin
            rd_base = base_q[i];
            rd_attr = attr_q[i];
         end
      end
   end

   // R5/R7: the tables only move when a write strobe is presented
   a_r7_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_base || wr_attr) |=> ($stable(base_flat) && $stable(attr_flat)));

   // R5: stored base words never carry bits below the base granule
   a_r5_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_base |=> (base_q[$past(wr_idx)][BASE_LSB-1:0] == '0));

endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
   import mpu_regbank_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 12,
   parameter int NUM_ALIAS   = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_req,
   input  logic                          bus_wr,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   output logic                          bus_ready,
   output logic                          prot_en,
   output logic                          fault_prot_en,
   output logic                          bg_map_en,
   output logic [NUM_REGIONS*32-1:0]     region_base,
   output logic [NUM_REGIONS*32-1:0]     region_attr,
   output logic                          tbl_changed
);

   localparam int CNT_W = IDX_W + 1;
   localparam logic [CNT_W-1:0] N_REG = CNT_W'(NUM_REGIONS);

   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > MAX_REGION) begin : g_bad_regions
         initial $error("mpu_regbank: NUM_REGIONS must be 1..16");
      end
   endgenerate

   reg_sel_e          sel;
   logic [CTRL_W-1:0] ctrl_q;
   logic [IDX_W-1:0]  rptr_q;
   logic              ready_q;
   logic              chg_q;
   logic [31:0]       rdata_q;
   logic [31:0]       rd_base, rd_attr;

   mpu_addr_decode #(.ADDR_W(ADDR_W), .NUM_ALIAS(NUM_ALIAS)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   logic             wr_go;
   logic             emb_flag;
   logic [IDX_W-1:0] emb_idx;
   logic             emb_ok, ptr_ok, rptr_wr_ok;
   logic             base_ok, attr_ok;
   logic [IDX_W-1:0] tgt_idx;

   assign wr_go      = bus_req && bus_wr;
   assign emb_flag   = bus_wdata[VALID_BIT];
   assign emb_idx    = bus_wdata[IDX_W-1:0];
   assign emb_ok     = ({1'b0, emb_idx} < N_REG);
   assign ptr_ok     = ({1'b0, rptr_q} < N_REG);
   assign rptr_wr_ok = (bus_wdata < 32'(NUM_REGIONS));
   assign base_ok    = wr_go && (sel == SEL_BASE) && (emb_flag ? emb_ok : ptr_ok);
   assign attr_ok    = wr_go && (sel == SEL_ATTR) && ptr_ok;
   assign tgt_idx    = (sel == SEL_BASE && emb_flag) ? emb_idx : rptr_q;

   mpu_region_table #(.NUM_REGIONS(NUM_REGIONS)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_base   (base_ok),
      .wr_attr   (attr_ok),
      .wr_idx    (tgt_idx),
      .wdata     (bus_wdata),
      .rd_idx    (rptr_q),
      .rd_base   (rd_base),
      .rd_attr   (rd_attr),
      .base_flat (region_base),
      .attr_flat (region_attr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         rptr_q <= '0;
      end else if (wr_go) begin
         if (sel == SEL_CTRL)
            ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (sel == SEL_RPTR && rptr_wr_ok)
            rptr_q <= bus_wdata[IDX_W-1:0];
         if (base_ok && emb_flag)
            rptr_q <= emb_idx;
      end
   end

   logic [31:0] rd_mux;
   always_comb begin
      unique case (sel)
         SEL_CTRL: rd_mux = {{(32-CTRL_W){1'b0}}, ctrl_q};
         SEL_RPTR: rd_mux = {{(32-IDX_W){1'b0}}, rptr_q};
         SEL_BASE: rd_mux = rd_base;
         SEL_ATTR: rd_mux = rd_attr;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         chg_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ready_q <= bus_req;
         chg_q   <= base_ok || attr_ok;
         rdata_q <= (bus_req && !bus_wr) ? rd_mux : '0;
      end
   end

   assign bus_ready     = ready_q;
   assign bus_rdata     = rdata_q;
   assign tbl_changed   = chg_q;
   assign prot_en       = ctrl_q[0];
   assign fault_prot_en = ctrl_q[1];
   assign bg_map_en     = ctrl_q[2];

   // R2: each request completes on the next cycle
   a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_ready);
   a_r2_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> !bus_ready);

   // R4: an oversized pointer write leaves the pointer alone
   a_r4_ptr_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && sel == SEL_RPTR && bus_wdata >= 32'(NUM_REGIONS)) |=> $stable(rptr_q));

   // R6: an embedded out-of-range region drops the whole write
   a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && sel == SEL_BASE && emb_flag && !emb_ok)
         |=> ($stable(rptr_q) && $stable(region_base) && !tbl_changed));

   // R9: undecoded writes touch nothing
   a_r9_hole: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && sel == SEL_NONE)
         |=> ($stable(ctrl_q) && $stable(rptr_q) && !tbl_changed));

   // R10: the change strobe only follows a write
   a_r10_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_changed |-> $past(bus_req && bus_wr));

endmodule

// File: tb/sim_mpu_regbank.sv
`timescale 1ns/1ps
module sim_mpu_regbank;

   localparam int N  = 6;
   localparam int AW = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_req = 1'b0;
   logic              bus_wr = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              bus_ready;
   logic              prot_en, fault_prot_en, bg_map_en;
   logic [N*32-1:0]   region_base, region_attr;
   logic              tbl_changed;

   always #4 clk = ~clk;

   mpu_regbank #(.NUM_REGIONS(N), .ADDR_W(AW), .NUM_ALIAS(3)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .prot_en(prot_en), .fault_prot_en(fault_prot_en),
      .bg_map_en(bg_map_en), .region_base(region_base), .region_attr(region_attr),
      .tbl_changed(tbl_changed)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [2:0]  m_ctrl;
   logic [3:0]  m_ptr;
   logic [31:0] m_base [N];
   logic [31:0] m_attr [N];

   // 0 none, 1 ctrl, 2 pointer, 3 base, 4 attr
   function automatic int kind(input logic [11:0] a);
      logic [11:0] w = {a[11:2], 2'b00};
      case (w)
         12'hD94: return 1;
         12'hD98: return 2;
         12'hD9C, 12'hDA4, 12'hDAC, 12'hDB4: return 3;
         12'hDA0, 12'hDA8, 12'hDB0, 12'hDB8: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] model_read(input logic [11:0] a);
      case (kind(a))
         1: return {29'd0, m_ctrl};
         2: return {28'd0, m_ptr};
         3: return m_base[m_ptr];
         4: return m_attr[m_ptr];
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_tables(input string req);
      for (int i = 0; i < N; i++) begin
         check(region_base[i*32 +: 32] == m_base[i], {req, " base"}, region_base[i*32 +: 32], m_base[i]);
         check(region_attr[i*32 +: 32] == m_attr[i], {req, " attr"}, region_attr[i*32 +: 32], m_attr[i]);
      end
      check({bg_map_en, fault_prot_en, prot_en} == m_ctrl, "R3 ctrl outputs",
            {29'd0, bg_map_en, fault_prot_en, prot_en}, {29'd0, m_ctrl});
   endtask

   task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                         input string req);
      logic [31:0] exp_rd;
      bit          exp_chg;
      exp_rd  = wr ? 32'd0 : model_read(a);
      exp_chg = 0;
      if (wr) begin
         case (kind(a))
            1: m_ctrl = d[2:0];
            2: if (d < N) m_ptr = d[3:0];
            3: begin
               if (d[4]) begin
                  if (d[3:0] < N) begin
                     m_ptr = d[3:0];
                     m_base[m_ptr] = {d[31:5], 5'd0};
                     exp_chg = 1;
                  end
               end else begin
                  m_base[m_ptr] = {d[31:5], 5'd0};
                  exp_chg = 1;
               end
            end
            4: begin m_attr[m_ptr] = d; exp_chg = 1; end
            default: ;
         endcase
      end
      @(negedge clk);
      bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
      check(bus_ready === 1'b1, {req, " R2 ready"}, {31'd0, bus_ready}, 32'd1);
      if (!wr) check(bus_rdata === exp_rd, {req, " rdata"}, bus_rdata, exp_rd);
      check(tbl_changed === exp_chg, {req, " R10 strobe"}, {31'd0, tbl_changed}, {31'd0, exp_chg});
      check_tables(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] dec_list [11];
      logic [31:0] seed_dummy;
      dec_list = '{12'hD94, 12'hD98, 12'hD9C, 12'hDA0, 12'hDA4, 12'hDA8,
                   12'hDAC, 12'hDB0, 12'hDB4, 12'hDB8, 12'hD90};
      seed_dummy = $urandom(32'd20240611);
      m_ctrl = '0; m_ptr = '0;
      for (int i = 0; i < N; i++) begin m_base[i] = '0; m_attr[i] = '0; end

      repeat (3) @(negedge clk);
      // R1: reset state
      check(bus_ready === 1'b0, "R1 ready idle", {31'd0, bus_ready}, 32'd0);
      check(tbl_changed === 1'b0, "R1 strobe idle", {31'd0, tbl_changed}, 32'd0);
      check_tables("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(bus_ready === 1'b0, "R2 no request", {31'd0, bus_ready}, 32'd0);

      // R3 control
      access(1, 12'hD94, 32'hFFFF_FFFD, "R3 ctrl write");
      access(0, 12'hD94, 0, "R3 ctrl read");
      // R4 pointer limits
      access(1, 12'hD98, N-1, "R4 ptr top");
      access(0, 12'hD98, 0, "R4 ptr read");
      access(1, 12'hD98, N, "R4 ptr reject N");
      access(1, 12'hD98, 32'h8000_0002, "R4 ptr reject huge");
      access(0, 12'hD98, 0, "R4 ptr kept");
      // R5 base via pointer, R7 attr
      access(1, 12'hD9C, 32'h1234_56EF, "R5 base write");
      access(0, 12'hD9C, 0, "R5 base read");
      access(1, 12'hDA0, 32'hA5A5_0F0F, "R7 attr write");
      access(0, 12'hDA0, 0, "R7 attr read");
      // R6 embedded region
      access(1, 12'hD9C, 32'h4000_0012, "R6 embedded ok");
      access(0, 12'hD98, 0, "R6 ptr moved");
      access(1, 12'hD9C, 32'h5000_0010 | N, "R6 embedded drop");
      access(1, 12'hD9C, 32'h6000_001F, "R6 embedded drop 15");
      access(0, 12'hD98, 0, "R6 ptr unchanged");
      // R8 aliases
      for (int w = 1; w < 4; w++) begin
         access(1, 12'(12'hD9C + 8*w), 32'h0100_0010 | w, "R8 alias base");
         access(1, 12'(12'hDA0 + 8*w), 32'hC000_0000 | w, "R8 alias attr");
         access(0, 12'(12'hDA0 + 8*w), 0, "R8 alias attr read");
         access(0, 12'hD9C, 0, "R8 primary sees alias");
      end
      // R9 holes
      access(1, 12'hDBC, 32'hFFFF_FFFF, "R9 hole write");
      access(0, 12'hDBC, 0, "R9 hole read");
      access(1, 12'hD90, 32'hFFFF_FFFF, "R9 hole write low");
      access(0, 12'h000, 0, "R9 hole read zero");

      // random mix (R11 tables compared after every access)
      for (int k = 0; k < 3000; k++) begin
         logic [11:0] a;
         logic [31:0] d;
         bit          wr;
         wr = ($urandom % 2) == 1;
         if (($urandom % 8) == 0) a = 12'($urandom) & 12'hFFC;
         else                    a = dec_list[$urandom % 11];
         d = $urandom;
         if (kind(a) == 2) d = ($urandom % 4 == 0) ? $urandom : ($urandom % 10);
         access(wr, a, d, "R11 random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule